// File: doc/BRIEF.md
# DMA Staging-Buffer Burst Scheduler

This block sequences one DMA channel that moves data from a source bus to a destination bus through an internal staging buffer. It only decides how much to move and in which direction. It issues one transfer request at a time. Each request carries a burst count, where one burst is 32 bytes, and a direction flag. The block then waits for the bus engine to report completion. It keeps the buffer fill level and the part of the total job that is still unread. The protocol engines, the data path and address generation are outside this block.

A job starts with a start pulse that carries four values: a buffer-size code, a source transfer size, a destination transfer size and a total length in bursts. The buffer holds one burst less than its nominal size. The block alternates between two phases. In the fill phase it reads from the source until the buffer is full or the job has been fully read. In the drain phase it writes to the destination until the buffer is empty. When the job has been fully read and the buffer is empty, the block goes idle.

Top module: `dma_burst_sched`

## Requirements
- R1: While reset is asserted and directly after it, `req_valid` is 0, `busy` is 0 and `fill_level` is 0.
- R2: The buffer-size code k (0..5) gives a usable capacity of 2^(k+1)-1 bursts. Codes 6 and 7 give 63 bursts. Code 5 is a 2048-byte buffer with a capacity of 63 bursts.
- R3: A fill request (`req_write`=0) carries the smallest of three values: the source size, the free capacity and the unread remainder of the job. A programmed size of 0 acts as 1.
- R4: The fill phase continues until the buffer is full or the whole job has been read. The next request is then a drain request. The reads of a job sum to its total length.
- R5: A drain request (`req_write`=1) carries the smaller of the destination size and the fill level. When the buffer holds less than the destination size, the last write takes what remains. A destination size of 0 acts as 1.
- R6: The drain phase continues until the level is 0. The block then returns to fill if unread data remains. Otherwise it drops `busy` with no further request.
- R7: A request holds its count and direction while `req_valid` is high and `req_ready` is low. After a request is accepted, `req_valid` stays low until `xfer_done` is received.
- R8: `fill_level` rises by the read count, and falls by the write count, on the cycle after `xfer_done`. It never exceeds the capacity.
- R9: A start pulse while `busy` is high is ignored, and its values are not taken. A start with a total length of 0 leaves the block idle.
- R10: With code 5, a source size of 63 and a 63-burst job, the buffer drains in a number of writes set by the destination size: 63 writes for size 1, 9 for size 7, 7 for size 9 and 1 for size 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; samples the configuration when idle |
| wrap_code | input | CODE_W | Buffer-size code |
| src_size | input | SZ_W | Source transfer size in bursts |
| dst_size | input | SZ_W | Destination transfer size in bursts |
| total_len | input | LEN_W | Job length in bursts |
| req_valid | output | 1 | A transfer request is presented |
| req_ready | input | 1 | The bus engine accepts the request |
| req_write | output | 1 | 1 = destination write, 0 = source read |
| req_bursts | output | SZ_W | Burst count of the request |
| xfer_done | input | 1 | Completion pulse for the accepted request |
| busy | output | 1 | A job is in progress |
| fill_level | output | SZ_W | Bursts currently held in the buffer |

## Verification
The sweep crosses every buffer-size code with source and destination sizes of 0, 1, 5 or 7, and 63, and job lengths of 0, 5 and 30. Small capacities against a large source size show whether free space clamps reads. Large capacities against short jobs show whether the unread remainder clamps them. Destination sizes that do not divide the level expose the short final write. The four 63-burst cases at code 5 tell apart the drain counts of 63, 9, 7 and 1. Start pulses injected mid-job show that a running job is not disturbed.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;
endpackage

// File: rtl/dbs_wrap_decode.sv
module dbs_wrap_decode #(
  parameter int CODE_W = 3,
  parameter int SZ_W   = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [SZ_W-1:0]   cap
);
  localparam int NCODE = 1 << CODE_W;
  localparam int TOPK  = SZ_W - 1;

  logic [SZ_W-1:0] cap_tbl [NCODE];

  // Entry k holds 2^(k+1)-1 bursts; codes above TOPK saturate.
  for (genvar g = 0; g < NCODE; g++) begin : g_ent
    localparam int K = (g > TOPK) ? TOPK : g;
    assign cap_tbl[g] = SZ_W'((1 << (K + 1)) - 1);
  end

  assign cap = cap_tbl[code];
endmodule

// File: rtl/dbs_cfg_regs.sv
module dbs_cfg_regs #(
  parameter int CODE_W = 3,
  parameter int SZ_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  input  logic [SZ_W-1:0]   src_in,
  input  logic [SZ_W-1:0]   dst_in,
  output logic [CODE_W-1:0] code_q,
  output logic [SZ_W-1:0]   src_q,
  output logic [SZ_W-1:0]   dst_q
);
  logic [CODE_W-1:0] code_d;
  logic [SZ_W-1:0]   src_d, dst_d;

  // A programmed size of zero is taken as a single burst.
  always_comb begin
    code_d = code_q;
    src_d  = src_q;
    dst_d  = dst_q;
    if (load) begin
      code_d = code_in;
      src_d  = (src_in == '0) ? SZ_W'(1) : src_in;
      dst_d  = (dst_in == '0) ? SZ_W'(1) : dst_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      src_q  <= SZ_W'(1);
      dst_q  <= SZ_W'(1);
    end else begin
      code_q <= code_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
    end
  end
endmodule

// File: rtl/dbs_level_ctr.sv
module dbs_level_ctr #(
  parameter int SZ_W  = 6,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] total_in,
  input  logic             upd,
  input  logic             upd_write,
  input  logic [SZ_W-1:0]  upd_cnt,
  output logic [SZ_W-1:0]  level,
  output logic [LEN_W-1:0] remain
);
  logic [SZ_W-1:0]  level_d;
  logic [LEN_W-1:0] remain_d;

  always_comb begin
    level_d  = level;
    remain_d = remain;
    if (load) begin
      level_d  = '0;
      remain_d = total_in;
    end else if (upd) begin
      if (upd_write) begin
        level_d = level - upd_cnt;
      end else begin
        level_d  = level + upd_cnt;
        remain_d = remain - LEN_W'(upd_cnt);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      remain <= '0;
    end else begin
      level  <= level_d;
      remain <= remain_d;
    end
  end
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int SZ_W  = 6,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [SZ_W-1:0]  cap,
  input  logic [SZ_W-1:0]  src_q,
  input  logic [SZ_W-1:0]  dst_q,
  input  logic [SZ_W-1:0]  level,
  input  logic [LEN_W-1:0] remain,
  input  logic             req_ready,
  input  logic             xfer_done,
  output logic             req_valid,
  output logic             req_write,
  output logic [SZ_W-1:0]  req_bursts,
  output logic             upd,
  output logic             upd_write,
  output logic [SZ_W-1:0]  upd_cnt,
  output logic             busy
);
  seq_state_e      state_q, state_d;
  phase_e          phase_q, phase_d;
  logic [SZ_W-1:0] cnt_q, cnt_d;

  logic [SZ_W-1:0]  space;
  logic [SZ_W-1:0]  rd_cnt, wr_cnt;
  logic [SZ_W-1:0]  lvl_after_rd, lvl_after_wr;
  logic [LEN_W-1:0] rem_after_rd;
  logic             rem_small;

  // Read count: smallest of source size, free space and unread remainder.
  always_comb begin
    space     = cap - level;
    rd_cnt    = (src_q < space) ? src_q : space;
    rem_small = (remain < LEN_W'(rd_cnt));
    if (rem_small) rd_cnt = remain[SZ_W-1:0];
    wr_cnt    = (dst_q < level) ? dst_q : level;
  end

  assign lvl_after_rd = level + cnt_q;
  assign lvl_after_wr = level - cnt_q;
  assign rem_after_rd = remain - LEN_W'(cnt_q);

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_REQ;
          phase_d = PH_FILL;
        end
      end
      ST_REQ: begin
        if (req_ready) begin
          state_d = ST_WAIT;
          cnt_d   = req_bursts;
        end
      end
      ST_WAIT: begin
        if (xfer_done) begin
          state_d = ST_REQ;
          if (phase_q == PH_FILL) begin
            if ((lvl_after_rd == cap) || (rem_after_rd == '0)) phase_d = PH_DRAIN;
          end else if (lvl_after_wr == '0) begin
            if (remain == '0) state_d = ST_IDLE;
            else              phase_d = PH_FILL;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_FILL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign req_valid  = (state_q == ST_REQ);
  assign req_write  = (phase_q == PH_DRAIN);
  assign req_bursts = (phase_q == PH_DRAIN) ? wr_cnt : rd_cnt;
  assign upd        = (state_q == ST_WAIT) && xfer_done;
  assign upd_write  = (phase_q == PH_DRAIN);
  assign upd_cnt    = cnt_q;
  assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/dma_burst_sched.sv
module dma_burst_sched #(
  parameter int CODE_W = 3,
  parameter int SZ_W   = 6,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] wrap_code,
  input  logic [SZ_W-1:0]   src_size,
  input  logic [SZ_W-1:0]   dst_size,
  input  logic [LEN_W-1:0]  total_len,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [SZ_W-1:0]   req_bursts,
  input  logic              xfer_done,
  output logic              busy,
  output logic [SZ_W-1:0]   fill_level
);
  logic              accept;
  logic [CODE_W-1:0] code_q;
  logic [SZ_W-1:0]   src_q, dst_q, cap_w;
  logic [LEN_W-1:0]  remain;
  logic              upd, upd_write;
  logic [SZ_W-1:0]   upd_cnt;

  assign accept = start && !busy && (total_len != '0);

  dbs_cfg_regs #(.CODE_W(CODE_W), .SZ_W(SZ_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .code_in (wrap_code),
    .src_in  (src_size),
    .dst_in  (dst_size),
    .code_q  (code_q),
    .src_q   (src_q),
    .dst_q   (dst_q)
  );

  dbs_wrap_decode #(.CODE_W(CODE_W), .SZ_W(SZ_W)) u_dec (
    .code (code_q),
    .cap  (cap_w)
  );

  dbs_level_ctr #(.SZ_W(SZ_W), .LEN_W(LEN_W)) u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .total_in  (total_len),
    .upd       (upd),
    .upd_write (upd_write),
    .upd_cnt   (upd_cnt),
    .level     (fill_level),
    .remain    (remain)
  );

  dbs_seq #(.SZ_W(SZ_W), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .cap        (cap_w),
    .src_q      (src_q),
    .dst_q      (dst_q),
    .level      (fill_level),
    .remain     (remain),
    .req_ready  (req_ready),
    .xfer_done  (xfer_done),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_bursts (req_bursts),
    .upd        (upd),
    .upd_write  (upd_write),
    .upd_cnt    (upd_cnt),
    .busy       (busy)
  );
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int SZ_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [SZ_W-1:0] req_bursts,
  input logic            xfer_done,
  input logic            busy,
  input logic [SZ_W-1:0] fill_level,
  input logic [SZ_W-1:0] cap
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       outstanding <= 1'b0;
    else if (req_valid && req_ready)  outstanding <= 1'b1;
    else if (xfer_done)               outstanding <= 1'b0;
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_bursts) && $stable(req_write));

  // R7
  no_issue_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !req_valid);

  // R8
  level_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= cap);

  // R3
  read_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |-> (req_bursts != '0) && (req_bursts <= cap - fill_level));

  // R5
  write_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> (req_bursts != '0) && (req_bursts <= fill_level));

  // R6
  end_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> fill_level == '0);
endmodule

bind dma_burst_sched dbs_checker #(.SZ_W(SZ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_bursts (req_bursts),
  .xfer_done  (xfer_done),
  .busy       (busy),
  .fill_level (fill_level),
  .cap        (cap_w)
);

// File: tb/tb_dma_burst_sched.sv
`timescale 1ns/1ps
module tb_dma_burst_sched;
  localparam int CODE_W = 3;
  localparam int SZ_W   = 6;
  localparam int LEN_W  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              start, req_ready, xfer_done;
  logic [CODE_W-1:0] wrap_code;
  logic [SZ_W-1:0]   src_size, dst_size;
  logic [LEN_W-1:0]  total_len;
  logic              req_valid, req_write, busy;
  logic [SZ_W-1:0]   req_bursts, fill_level;

  dma_burst_sched #(.CODE_W(CODE_W), .SZ_W(SZ_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wrap_code(wrap_code),
    .src_size(src_size), .dst_size(dst_size), .total_len(total_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bursts(req_bursts), .xfer_done(xfer_done), .busy(busy),
    .fill_level(fill_level)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_cap(input int c);
    return (c > 5) ? 63 : ((1 << (c + 1)) - 1);
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic run_job(input int c, input int s, input int d, input int t, input bit poke, output int nwr);
    int  lvl = 0;
    int  rem = t;
    int  cap = exp_cap(c);
    int  se  = (s == 0) ? 1 : s;
    int  de  = (d == 0) ? 1 : d;
    bit  drain = 0;
    bit  bad = 0;
    bit  over = 0;
    int  nreq = 0;
    int  rdsum = 0;
    int  ex;
    nwr = 0;
    @(negedge clk);
    wrap_code = CODE_W'(c); src_size = SZ_W'(s); dst_size = SZ_W'(d);
    total_len = LEN_W'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (t == 0) begin
      // R9: zero-length start leaves the block idle
      chk(!busy && !req_valid, "R9", busy, 0, "busy after zero-length start");
      return;
    end
    while (!bad && !over) begin
      if (!req_valid) begin
        bad = 1; chk(0, "R4", 0, 1, "request missing"); break;
      end
      ex = drain ? imin(de, lvl) : imin(imin(se, cap - lvl), rem);
      if (nreq == 0 && se >= cap && t >= cap)
        chk(int'(req_bursts) == cap, "R2", req_bursts, cap, "first read equals capacity");
      if (int'(req_bursts) != ex || req_write != drain) begin
        bad = 1;
        chk(0, drain ? "R5" : "R3", req_bursts, ex, "burst count");
        break;
      end
      if (nreq % 3 == 1) begin
        @(negedge clk);
        if (!req_valid || int'(req_bursts) != ex) begin
          bad = 1; chk(0, "R7", req_bursts, ex, "held request"); break;
        end
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      for (int w = 0; w < 1 + nreq % 2; w++) begin
        if (req_valid) begin
          bad = 1; chk(0, "R7", 1, 0, "valid while outstanding");
        end
        if (poke) begin
          start = 1'b1; total_len = LEN_W'(3); dst_size = SZ_W'(2);
        end
        @(negedge clk);
      end
      start = 1'b0;
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      if (drain) begin
        lvl -= ex; nwr++;
        if (lvl == 0) begin
          if (rem == 0) over = 1;
          else drain = 0;
        end
      end else begin
        lvl += ex; rem -= ex; rdsum += ex;
        if (lvl == cap || rem == 0) drain = 1;
      end
      if (int'(fill_level) != lvl) begin
        bad = 1; chk(0, "R8", fill_level, lvl, "fill level");
      end
      nreq++;
    end
    if (!bad) begin
      chk(1, "R3", 0, 0, "request sequence");
      chk(rdsum == t, "R4", rdsum, t, "sum of reads");
      // R6: no request and busy low once drained
      chk(!busy && !req_valid, "R6", busy, 0, "busy after final drain");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int srcs [4] = '{0, 1, 5, 63};
    int dsts [4] = '{0, 1, 7, 63};
    int lens [3] = '{0, 5, 30};
    int docd [4] = '{1, 7, 9, 63};
    int docn [4] = '{63, 9, 7, 1};
    start = 0; req_ready = 0; xfer_done = 0;
    wrap_code = '0; src_size = '0; dst_size = '0; total_len = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!req_valid && !busy && fill_level == '0, "R1", busy, 0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid && !busy && fill_level == '0, "R1", req_valid, 0, "outputs after reset");

    for (int c = 0; c < 8; c++)
      for (int si = 0; si < 4; si++)
        for (int di = 0; di < 4; di++)
          for (int li = 0; li < 3; li++)
            run_job(c, srcs[si], dsts[di], lens[li], 1'b0, n);

    // R10 and R9: documented drain counts, with start pulses injected mid-job
    for (int k = 0; k < 4; k++) begin
      run_job(5, 63, docd[k], 63, 1'b1, n);
      chk(n == docn[k], "R10", n, docn[k], "drain write count");
    end
    // R9: a longer job with interference still ends with the original length
    run_job(2, 4, 3, 20, 1'b1, n);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule